// File: doc/BRIEF.md
# Speculative Memory Read Predictor

This block sits beside the last-level cache partition. For every request that misses in the local partition, it decides whether to send an early read to the memory controller while the coherent lookup is still in progress. A useful early read hides part of the memory latency. A wasted one costs memory bandwidth. The block therefore learns from outcome feedback: it keeps one usefulness history for data requests and a second one for instruction fetches. Each history is gated by a threshold that software can program.

Each history is a saturating counter. It counts up when an early read proved useful and down when it was wasted. A miss triggers an early read in the following cycle only if the counter for its request kind has reached that kind's threshold. Two threshold values have a fixed meaning: the bottom value forces speculation on for every miss, and the top value turns it off. Issued reads are remembered by request ID. When the outcome for an ID comes back, it is credited to the kind recorded at issue time. Outcomes for IDs that have no outstanding read are dropped.

Top module: `specrd_predictor`

## Requirements
- R1: When `miss_valid` is high, `spec_issue` goes high on the following cycle if the selected history counter is greater than or equal to the selected threshold and that threshold is not 15. `spec_id` then equals the miss ID. Without a miss, `spec_issue` is low on the following cycle.
- R2: `miss_is_instr` selects the history and threshold: 0 means data, 1 means instruction. The two histories never affect each other's decisions.
- R3: Each history is a 4-bit counter. It rises by one on useful feedback (`fb_useful`=1) and falls by one on wasted feedback (`fb_useful`=0). It holds at 15 on further useful feedback and at 0 on further wasted feedback.
- R4: A threshold of 0 makes every miss of that kind issue, whatever the counter value.
- R5: A threshold of 15 blocks every miss of that kind, even when the counter is 15.
- R6: Feedback is acted on only for an ID that has an outstanding early read. It updates the history of the kind recorded at issue and retires the ID. Feedback for any other ID changes nothing.
- R7: When a miss and a feedback arrive in the same cycle, the issue decision uses the counter value from before that feedback.
- R8: After reset both counters and both thresholds are 8, `spec_issue` is low, and no ID is outstanding.
- R9: A cycle with `cfg_we` high loads `cfg_wdata` into the threshold chosen by `cfg_sel` (0 data, 1 instruction). The new value is used from the next cycle on. `cfg_rdata` shows the threshold chosen by `cfg_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Local partition miss present |
| miss_is_instr | input | 1 | Miss kind: 0 data, 1 instruction |
| miss_id | input | ID_W | Request ID of the miss |
| fb_valid | input | 1 | Outcome feedback present |
| fb_id | input | ID_W | Request ID the feedback refers to |
| fb_useful | input | 1 | 1 if the early read was useful, 0 if wasted |
| cfg_we | input | 1 | Threshold write strobe |
| cfg_sel | input | 1 | Threshold select: 0 data, 1 instruction |
| cfg_wdata | input | CNT_W | Threshold write value |
| cfg_rdata | output | CNT_W | Selected threshold value |
| spec_issue | output | 1 | Early memory read issued this cycle |
| spec_id | output | ID_W | Request ID of the early read |

## Verification
The bench builds the block with `ID_W` = 3. With only eight tracked IDs, a test can issue a read on every slot, retire all of them, and repeat. Two such rounds take a counter from its reset value of 8 past either end of its range, so both saturation points are reached in a few dozen cycles. The small ID space also makes it easy to send feedback for a slot that was never issued, or for one that has already retired. Thresholds 0, 1, 7, 14 and 15 are all used, which places the force-on and force-off settings next to ordinary compare points.

// File: rtl/specrd_pkg.sv
package specrd_pkg;
  typedef enum logic {
    KIND_DATA  = 1'b0,
    KIND_INSTR = 1'b1
  } req_kind_e;

  localparam int KIND_COUNT = 2;
endpackage

// File: rtl/specrd_hist.sv
module specrd_hist #(
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             upd_up,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (upd_en) begin
      if (upd_up) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RST;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/specrd_thr_reg.sv
module specrd_thr_reg #(
  parameter int CNT_W    = 4,
  parameter int THR_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] thr_o
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(THR_INIT);

  logic [CNT_W-1:0] thr_q;
  logic [CNT_W-1:0] thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) thr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_RST;
    end else if (wr_en) begin
      thr_q <= thr_d;
    end
  end

  assign thr_o = thr_q;
endmodule

// File: rtl/specrd_tracker.sv
module specrd_tracker #(
  parameter int ID_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_en,
  input  logic [ID_W-1:0]      alloc_id,
  input  logic                 alloc_kind,
  input  logic                 ret_en,
  input  logic [ID_W-1:0]      ret_id,
  output logic                 hit_o,
  output logic                 hit_kind_o,
  output logic [(1<<ID_W)-1:0] pend_o
);
  localparam int NUM_IDS = 1 << ID_W;

  logic [NUM_IDS-1:0] pend_q;
  logic [NUM_IDS-1:0] kind_q;

  for (genvar e = 0; e < NUM_IDS; e++) begin : g_slot
    logic set_e;
    logic clr_e;
    logic pend_d;

    assign set_e = alloc_en && (alloc_id == ID_W'(e));
    assign clr_e = ret_en && (ret_id == ID_W'(e));

    always_comb begin
      pend_d = pend_q[e];
      if (clr_e) pend_d = 1'b0;
      if (set_e) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[e] <= 1'b0;
      end else if (set_e || clr_e) begin
        pend_q[e] <= pend_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        kind_q[e] <= 1'b0;
      end else if (set_e) begin
        kind_q[e] <= alloc_kind;
      end
    end
  end

  assign hit_o      = ret_en && pend_q[ret_id];
  assign hit_kind_o = kind_q[ret_id];
  assign pend_o     = pend_q;
endmodule

// File: rtl/specrd_predictor.sv
module specrd_predictor
  import specrd_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 8,
  parameter int THR_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  input  logic             miss_is_instr,
  input  logic [ID_W-1:0]  miss_id,
  input  logic             fb_valid,
  input  logic [ID_W-1:0]  fb_id,
  input  logic             fb_useful,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] cfg_rdata,
  output logic             spec_issue,
  output logic [ID_W-1:0]  spec_id
);
  localparam int               NUM_IDS = 1 << ID_W;
  localparam logic [CNT_W-1:0] THR_OFF = '1;

  logic [CNT_W-1:0]   cnt [KIND_COUNT];
  logic [CNT_W-1:0]   thr [KIND_COUNT];
  logic               fb_hit;
  logic               fb_kind;
  logic [NUM_IDS-1:0] pend_vld;
  req_kind_e          miss_kind;
  logic [CNT_W-1:0]   sel_cnt;
  logic [CNT_W-1:0]   sel_thr;
  logic               allow;
  logic               issue_d;
  logic               issue_q;
  logic [ID_W-1:0]    id_q;

  for (genvar k = 0; k < KIND_COUNT; k++) begin : g_kind
    logic upd_en_k;
    logic wr_en_k;

    assign upd_en_k = fb_hit && (fb_kind == 1'(k));
    assign wr_en_k  = cfg_we && (cfg_sel == 1'(k));

    specrd_hist #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_en (upd_en_k),
      .upd_up (fb_useful),
      .cnt_o  (cnt[k])
    );

    specrd_thr_reg #(.CNT_W(CNT_W), .THR_INIT(THR_INIT)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en_k),
      .wr_data (cfg_wdata),
      .thr_o   (thr[k])
    );
  end

  specrd_tracker #(.ID_W(ID_W)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (issue_d),
    .alloc_id   (miss_id),
    .alloc_kind (miss_is_instr),
    .ret_en     (fb_valid),
    .ret_id     (fb_id),
    .hit_o      (fb_hit),
    .hit_kind_o (fb_kind),
    .pend_o     (pend_vld)
  );

  // The decision reads the registered counters, so a feedback in the same
  // cycle only becomes visible to the next miss (R7).
  always_comb begin
    miss_kind = req_kind_e'(miss_is_instr);
    sel_cnt   = cnt[miss_kind];
    sel_thr   = thr[miss_kind];
    allow     = (sel_thr != THR_OFF) && (sel_cnt >= sel_thr);
    issue_d   = miss_valid && allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
    end else begin
      issue_q <= issue_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= '0;
    end else if (miss_valid) begin
      id_q <= miss_id;
    end
  end

  logic [CNT_W-1:0] cnt_data;
  logic [CNT_W-1:0] cnt_instr;
  logic [CNT_W-1:0] thr_data;
  logic [CNT_W-1:0] thr_instr;

  assign cnt_data   = cnt[KIND_DATA];
  assign cnt_instr  = cnt[KIND_INSTR];
  assign thr_data   = thr[KIND_DATA];
  assign thr_instr  = thr[KIND_INSTR];
  assign cfg_rdata  = thr[cfg_sel];
  assign spec_issue = issue_q;
  assign spec_id    = id_q;
endmodule

// File: rtl/specrd_predictor_chk.sv
module specrd_predictor_chk #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 miss_valid,
  input logic                 miss_is_instr,
  input logic [ID_W-1:0]      miss_id,
  input logic                 fb_valid,
  input logic [ID_W-1:0]      fb_id,
  input logic                 spec_issue,
  input logic [ID_W-1:0]      spec_id,
  input logic [CNT_W-1:0]     cnt_data,
  input logic [CNT_W-1:0]     cnt_instr,
  input logic [CNT_W-1:0]     thr_data,
  input logic [CNT_W-1:0]     thr_instr,
  input logic [(1<<ID_W)-1:0] pend_vld
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] thr_sel;
  assign thr_sel = miss_is_instr ? thr_instr : thr_data;

  AST_ISSUE_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    spec_issue |-> $past(miss_valid)); // R1

  AST_ID_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    spec_issue |-> (spec_id == $past(miss_id))); // R1

  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && thr_sel == '0) |=> spec_issue); // R4

  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && thr_sel == TOP) |=> !spec_issue); // R5

  AST_DATA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_data > $past(cnt_data)) |-> (cnt_data == $past(cnt_data) + CNT_W'(1))); // R3

  AST_INSTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_instr < $past(cnt_instr)) |-> (cnt_instr == $past(cnt_instr) - CNT_W'(1))); // R3

  AST_STRAY_FB_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && !pend_vld[fb_id]) |=> ($stable(cnt_data) && $stable(cnt_instr))); // R6
endmodule

bind specrd_predictor specrd_predictor_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .miss_is_instr (miss_is_instr),
  .miss_id       (miss_id),
  .fb_valid      (fb_valid),
  .fb_id         (fb_id),
  .spec_issue    (spec_issue),
  .spec_id       (spec_id),
  .cnt_data      (cnt_data),
  .cnt_instr     (cnt_instr),
  .thr_data      (thr_data),
  .thr_instr     (thr_instr),
  .pend_vld      (pend_vld)
);

// File: tb/sim_specrd_predictor.sv
module sim_specrd_predictor;
  localparam int ID_W  = 3;
  localparam int CNT_W = 4;

  logic             clk;
  logic             rst_n;
  logic             miss_valid;
  logic             miss_is_instr;
  logic [ID_W-1:0]  miss_id;
  logic             fb_valid;
  logic [ID_W-1:0]  fb_id;
  logic             fb_useful;
  logic             cfg_we;
  logic             cfg_sel;
  logic [CNT_W-1:0] cfg_wdata;
  logic [CNT_W-1:0] cfg_rdata;
  logic             spec_issue;
  logic [ID_W-1:0]  spec_id;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  specrd_predictor #(.ID_W(ID_W), .CNT_W(CNT_W)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_is_instr (miss_is_instr),
    .miss_id       (miss_id),
    .fb_valid      (fb_valid),
    .fb_id         (fb_id),
    .fb_useful     (fb_useful),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_wdata     (cfg_wdata),
    .cfg_rdata     (cfg_rdata),
    .spec_issue    (spec_issue),
    .spec_id       (spec_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       cw;
    logic       cs;
    logic [3:0] cd;
    logic       mv;
    logic       mi;
    logic [2:0] mid;
    logic       fv;
    logic [2:0] fid;
    logic       fu;
    logic       ei;
  } vec_t;

  // Reset state: both counters 8, both thresholds 8.
  localparam vec_t VEC [17] = '{
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b1}, // data 8>=8 issues
    '{1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0, 1'b0}, // id0 wasted: data 7
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd1, 1'b0, 3'd0, 1'b0, 1'b0}, // data 7<8
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 3'd1, 1'b0, 3'd0, 1'b0, 1'b1}, // instr 8>=8
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd2, 1'b1, 3'd1, 1'b1, 1'b0}, // instr 9, data blocked
    '{1'b1, 1'b0, 4'd7,  1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // data thr 7
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd2, 1'b0, 3'd0, 1'b0, 1'b1}, // data 7>=7
    '{1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0, 1'b0}, // stray id5 ignored
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd3, 1'b0, 3'd0, 1'b0, 1'b1}, // data still 7
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd4, 1'b1, 3'd2, 1'b0, 1'b1}, // same cycle: old 7
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd5, 1'b0, 3'd0, 1'b0, 1'b0}, // data 6<7
    '{1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 1'b1, 1'b0}, // retired id2 ignored
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd6, 1'b0, 3'd0, 1'b0, 1'b0}, // data still 6
    '{1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b1, 1'b0}, // id3 useful: data 7
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b0, 3'd6, 1'b0, 3'd0, 1'b0, 1'b1}, // data 7>=7
    '{1'b1, 1'b1, 4'd15, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0}, // instr thr 15
    '{1'b0, 1'b0, 4'd0,  1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 1'b0}  // instr off
  };

  task automatic step(input logic cw, input logic cs, input logic [3:0] cd,
                      input logic mv, input logic mi, input logic [2:0] mid,
                      input logic fv, input logic [2:0] fid, input logic fu);
    @(negedge clk);
    cfg_we = cw; cfg_sel = cs; cfg_wdata = cd;
    miss_valid = mv; miss_is_instr = mi; miss_id = mid;
    fb_valid = fv; fb_id = fid; fb_useful = fu;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(0, 0, 4'd0, 0, 0, 3'd0, 0, 3'd0, 0);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
    miss_valid = 0; miss_is_instr = 0; miss_id = '0;
    fb_valid = 0; fb_id = '0; fb_useful = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_thr(input logic sel, input logic [3:0] val);
    step(1, sel, val, 0, 0, 3'd0, 0, 3'd0, 0);
  endtask

  task automatic miss_chk(input logic instr, input logic [2:0] id, input logic exp, input string tag);
    step(0, 0, 4'd0, 1, instr, id, 0, 3'd0, 0);
    check(tag, 8'(spec_issue), 8'(exp));
    if (exp) check(tag, 8'(spec_id), 8'(id));
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset();

    // R8: reset state
    idle();
    check("R8 issue after reset", 8'(spec_issue), 8'd0);
    @(negedge clk); cfg_sel = 0; #1;
    check("R8 data threshold reset", 8'(cfg_rdata), 8'd8);
    cfg_sel = 1; #1;
    check("R8 instr threshold reset", 8'(cfg_rdata), 8'd8);

    // Vector table: covers R1 R2 R6 R7 R9
    for (int i = 0; i < 17; i++) begin
      step(VEC[i].cw, VEC[i].cs, VEC[i].cd, VEC[i].mv, VEC[i].mi, VEC[i].mid,
           VEC[i].fv, VEC[i].fid, VEC[i].fu);
      check($sformatf("R1 table row %0d issue", i), 8'(spec_issue), 8'(VEC[i].ei));
      if (VEC[i].ei) check($sformatf("R1 table row %0d id", i), 8'(spec_id), 8'(VEC[i].mid));
    end

    // R9: readback of written thresholds
    @(negedge clk); cfg_we = 0; cfg_sel = 0; #1;
    check("R9 data threshold readback", 8'(cfg_rdata), 8'd7);
    cfg_sel = 1; #1;
    check("R9 instr threshold readback", 8'(cfg_rdata), 8'd15);

    // R3 floor and R4 force-on on the data history
    do_reset();
    set_thr(0, 4'd0);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 8; i++) miss_chk(0, 3'(i), 1'b1, "R4 forced issue");
      for (int i = 0; i < 8; i++) step(0, 0, 4'd0, 0, 0, 3'd0, 1, 3'(i), 0);
    end
    set_thr(0, 4'd1);
    miss_chk(0, 3'd2, 1'b0, "R3 data floor held at 0");
    miss_chk(1, 3'd3, 1'b1, "R2 instr history untouched");
    set_thr(0, 4'd0);
    miss_chk(0, 3'd4, 1'b1, "R4 thr 0 with counter 0");

    // R3 ceiling and R5 force-off on the instruction history
    do_reset();
    set_thr(1, 4'd0);
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 8; i++) miss_chk(1, 3'(i), 1'b1, "R4 forced instr issue");
      for (int i = 0; i < 8; i++) step(0, 0, 4'd0, 0, 0, 3'd0, 1, 3'(i), 1);
    end
    set_thr(1, 4'd15);
    miss_chk(1, 3'd1, 1'b0, "R5 thr 15 blocks counter 15");
    set_thr(1, 4'd14);
    miss_chk(1, 3'd5, 1'b1, "R3 instr ceiling held at 15");
    miss_chk(0, 3'd6, 1'b1, "R2 data history at reset value");
    idle();
    check("R1 no issue without miss", 8'(spec_issue), 8'd0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule